// File: doc/BRIEF.md
# Accumulator ALU with flags

This block is the arithmetic and logic unit of a small accumulator machine. It takes an 8-bit opcode and two 16-bit register operands and produces a 16-bit result. The result always goes to the accumulator, whichever registers supplied the operands. It supports addition, subtraction, bitwise AND, OR, XOR and complement, and one-bit shifts in either direction.

A four-bit flag register records the state of the last accepted operation: zero, carry, negative and overflow. The result output is combinational from the present inputs. The flag register loads only on a clock edge where the valid strobe is high and the opcode is one the unit recognises. Subtraction copies the sign of its result into carry. Both shifts return the bit that leaves the word through carry.

The opcode is first decoded into an enumerated operation kind. The kinds are ADD, SUB, AND, OR, XOR, NOT, SHL, SHR, and NONE for any other byte. Each kind selects one datapath branch and one flag-update rule. The flag register has two conditions. It holds when valid is low or the kind is NONE. It loads when valid is high and the kind is recognised.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0x01 (ADD) gives result = a + b mod 2^16. Carry is set to the carry out of bit 15. Overflow is set when a and b share a sign and the result sign differs from it.
- R2: Opcode 0x09 (SUB) gives result = a - b mod 2^16. Carry is set to result bit 15. Overflow is set when a and b differ in sign and the result sign differs from the sign of a.
- R3: Opcodes 0x11, 0x15 and 0x19 give a AND b, a OR b and a XOR b.
- R4: Opcode 0x1D (NOT) gives the bitwise complement of a. Operand b has no effect on the result or on the flags.
- R5: Opcode 0x21 (SHL) gives a shifted left by one, with bit 0 set to zero. Carry receives the old bit 15 of a.
- R6: Opcode 0x25 (SHR) gives a shifted right by one, with bit 15 set to zero. Carry receives the old bit 0 of a.
- R7: On a recognised operation, zero is set exactly when the 16-bit result is 0, and negative equals result bit 15.
- R8: AND, OR, XOR, NOT, SHL and SHR clear overflow. AND, OR, XOR and NOT leave carry unchanged.
- R9: The flag register changes only on a rising edge with valid high and a recognised opcode. Any other opcode, or valid low, leaves the flags unchanged. An unrecognised opcode drives the result to 0.
- R10: Active-low asynchronous reset clears all four flags to 0. The flag nibble is laid out as bit 0 = zero, bit 1 = carry, bit 2 = negative, bit 3 = overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Strobe; the flag register loads on this edge when the opcode is recognised |
| opcode_i | input | 8 | Operation code |
| src_a_i | input | 16 | First operand |
| src_b_i | input | 16 | Second operand |
| acc_o | output | 16 | Result destined for the accumulator |
| flags_o | output | 4 | Flag register {overflow, negative, carry, zero} |

## Verification
The assertions assume that the opcode and both operands are stable across each clock edge where valid is high. They compare the flags after an edge with the result seen just before that edge, so a change at the edge would break the comparison. The bench drives every input on the falling edge and holds it through the following rising edge, so this assumption holds. Random opcodes are drawn from the eight recognised values and from unassigned bytes, and valid is low about a quarter of the time. The operands are random, mixed with directed sign-boundary and all-zero or all-one values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
    localparam int OPC_W = 8;

    localparam logic [OPC_W-1:0] OPC_ADD = 8'h01;
    localparam logic [OPC_W-1:0] OPC_SUB = 8'h09;
    localparam logic [OPC_W-1:0] OPC_AND = 8'h11;
    localparam logic [OPC_W-1:0] OPC_OR  = 8'h15;
    localparam logic [OPC_W-1:0] OPC_XOR = 8'h19;
    localparam logic [OPC_W-1:0] OPC_NOT = 8'h1D;
    localparam logic [OPC_W-1:0] OPC_SHL = 8'h21;
    localparam logic [OPC_W-1:0] OPC_SHR = 8'h25;

    typedef enum logic [3:0] {
        K_NONE, K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOT, K_SHL, K_SHR
    } op_kind_e;

    localparam int FLG_Z = 0;
    localparam int FLG_C = 1;
    localparam int FLG_N = 2;
    localparam int FLG_V = 3;
    localparam int FLG_W = 4;
endpackage

// File: rtl/acc_alu_decode.sv
module acc_alu_decode
    import acc_alu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output op_kind_e         kind_o
);
    always_comb begin
        unique case (opcode_i)
            OPC_ADD: kind_o = K_ADD;
            OPC_SUB: kind_o = K_SUB;
            OPC_AND: kind_o = K_AND;
            OPC_OR:  kind_o = K_OR;
            OPC_XOR: kind_o = K_XOR;
            OPC_NOT: kind_o = K_NOT;
            OPC_SHL: kind_o = K_SHL;
            OPC_SHR: kind_o = K_SHR;
            default: kind_o = K_NONE;
        endcase
    end
endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  op_kind_e         kind_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] res_o,
    output logic             carry_we_o,
    output logic             carry_o,
    output logic             ovf_o
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] sum_ext;
    logic [WIDTH:0] dif_ext;

    assign sum_ext = {1'b0, a_i} + {1'b0, b_i};
    assign dif_ext = {1'b0, a_i} - {1'b0, b_i};

    always_comb begin
        res_o      = '0;
        carry_we_o = 1'b0;
        carry_o    = 1'b0;
        ovf_o      = 1'b0;
        unique case (kind_i)
            K_ADD: begin
                res_o      = sum_ext[MSB:0];
                carry_we_o = 1'b1;
                carry_o    = sum_ext[WIDTH];
                ovf_o      = (a_i[MSB] == b_i[MSB]) && (sum_ext[MSB] != a_i[MSB]);
            end
            K_SUB: begin
                res_o      = dif_ext[MSB:0];
                carry_we_o = 1'b1;
                carry_o    = dif_ext[MSB];
                ovf_o      = (a_i[MSB] != b_i[MSB]) && (dif_ext[MSB] != a_i[MSB]);
            end
            K_AND: res_o = a_i & b_i;
            K_OR:  res_o = a_i | b_i;
            K_XOR: res_o = a_i ^ b_i;
            K_NOT: res_o = ~a_i;
            K_SHL: begin
                res_o      = {a_i[MSB-1:0], 1'b0};
                carry_we_o = 1'b1;
                carry_o    = a_i[MSB];
            end
            K_SHR: begin
                res_o      = {1'b0, a_i[MSB:1]};
                carry_we_o = 1'b1;
                carry_o    = a_i[0];
            end
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/acc_alu_flags.sv
module acc_alu_flags
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [WIDTH-1:0] res_i,
    input  logic             carry_we_i,
    input  logic             carry_i,
    input  logic             ovf_i,
    output logic [FLG_W-1:0] flags_o
);
    logic [FLG_W-1:0] flags_q;
    logic [FLG_W-1:0] flags_d;

    always_comb begin
        flags_d        = flags_q;
        flags_d[FLG_Z] = (res_i == '0);
        flags_d[FLG_N] = res_i[WIDTH-1];
        flags_d[FLG_V] = ovf_i;
        if (carry_we_i) flags_d[FLG_C] = carry_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flags_q <= '0;
        else if (load_i) flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_q));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [7:0]       opcode_i,
    input  logic [WIDTH-1:0] src_a_i,
    input  logic [WIDTH-1:0] src_b_i,
    output logic [WIDTH-1:0] acc_o,
    output logic [3:0]       flags_o
);
    op_kind_e         kind;
    logic             carry_we;
    logic             carry_v;
    logic             ovf_v;
    logic             load;

    acc_alu_decode u_dec (
        .opcode_i (opcode_i),
        .kind_o   (kind)
    );

    acc_alu_datapath #(.WIDTH(WIDTH)) u_dp (
        .kind_i     (kind),
        .a_i        (src_a_i),
        .b_i        (src_b_i),
        .res_o      (acc_o),
        .carry_we_o (carry_we),
        .carry_o    (carry_v),
        .ovf_o      (ovf_v)
    );

    assign load = valid_i && (kind != K_NONE);

    acc_alu_flags #(.WIDTH(WIDTH)) u_flg (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .res_i      (acc_o),
        .carry_we_i (carry_we),
        .carry_i    (carry_v),
        .ovf_i      (ovf_v),
        .flags_o    (flags_o)
    );

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> flags_o[FLG_Z] == ($past(acc_o) == '0));
    // R7
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> flags_o[FLG_N] == $past(acc_o[WIDTH-1]));
    // R2
    sub_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && opcode_i == OPC_SUB) |=> flags_o[FLG_C] == flags_o[FLG_N]);
    // R8
    logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && (opcode_i == OPC_AND || opcode_i == OPC_OR ||
                     opcode_i == OPC_XOR || opcode_i == OPC_NOT))
        |=> ($stable(flags_o[FLG_C]) && !flags_o[FLG_V]));
    // R9
    unknown_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == K_NONE) |-> (acc_o == '0));
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [7:0]  opcode_i = 8'h00;
    logic [15:0] src_a_i = '0;
    logic [15:0] src_b_i = '0;
    logic [15:0] acc_o;
    logic [3:0]  flags_o;

    int tests = 0;
    int fails = 0;
    logic [3:0] model_f = 4'h0;

    always #5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .opcode_i(opcode_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .acc_o(acc_o), .flags_o(flags_o)
    );

    function automatic string tag_of(input logic [7:0] op);
        case (op)
            8'h01: return "R1";
            8'h09: return "R2";
            8'h11, 8'h15, 8'h19: return "R3";
            8'h1D: return "R4";
            8'h21: return "R5";
            8'h25: return "R6";
            default: return "R9";
        endcase
    endfunction

    function automatic logic known(input logic [7:0] op);
        return op inside {8'h01, 8'h09, 8'h11, 8'h15, 8'h19, 8'h1D, 8'h21, 8'h25};
    endfunction

    function automatic logic [15:0] exp_res(input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
        case (op)
            8'h01: return a + b;
            8'h09: return a - b;
            8'h11: return a & b;
            8'h15: return a | b;
            8'h19: return a ^ b;
            8'h1D: return ~a;
            8'h21: return a << 1;
            8'h25: return a >> 1;
            default: return 16'h0;
        endcase
    endfunction

    function automatic logic [3:0] exp_flags(input logic [7:0] op, input logic [15:0] a,
                                             input logic [15:0] b, input logic [3:0] old);
        logic [16:0] s;
        logic [15:0] r;
        logic c, v;
        r = exp_res(op, a, b);
        c = old[1];
        v = 1'b0;
        case (op)
            8'h01: begin s = {1'b0, a} + {1'b0, b}; c = s[16];
                         v = (a[15] == b[15]) && (r[15] != a[15]); end
            8'h09: begin c = r[15]; v = (a[15] != b[15]) && (r[15] != a[15]); end
            8'h21: c = a[15];
            8'h25: c = a[0];
            default: ;
        endcase
        return {v, r[15], c, (r == 16'h0)};
    endfunction

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic v, input logic [7:0] op, input logic [15:0] a, input logic [15:0] b);
        string t;
        t = tag_of(op);
        valid_i = v; opcode_i = op; src_a_i = a; src_b_i = b;
        #1;
        check(t, acc_o, exp_res(op, a, b));
        if (v && known(op)) model_f = exp_flags(op, a, b, model_f);
        @(negedge clk);
        if (v && known(op)) begin
            check((op == 8'h1D || op == 8'h11 || op == 8'h15 || op == 8'h19) ? "R8" : "R7",
                  {12'h0, flags_o}, {12'h0, model_f});
        end else begin
            check("R9", {12'h0, flags_o}, {12'h0, model_f});
        end
    endtask

    logic done = 1'b0;

    initial begin
        #1500000;
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] ops [8];
        logic [31:0] seed;
        logic [15:0] ra, rb;
        logic [7:0] rop;
        ops[0] = 8'h01; ops[1] = 8'h09; ops[2] = 8'h11; ops[3] = 8'h15;
        ops[4] = 8'h19; ops[5] = 8'h1D; ops[6] = 8'h21; ops[7] = 8'h25;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10", {12'h0, flags_o}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // directed corners
        step(1, 8'h01, 16'h7FFF, 16'h0001);  // R1 signed overflow
        step(1, 8'h01, 16'hFFFF, 16'h0001);  // R1 carry out, zero
        step(1, 8'h09, 16'h8000, 16'h0001);  // R2 overflow
        step(1, 8'h09, 16'h0001, 16'h0002);  // R2 carry = negative
        step(1, 8'h09, 16'h1234, 16'h1234);  // R2 zero
        step(1, 8'h21, 16'h8001, 16'h0000);  // R5 carry out
        step(1, 8'h11, 16'hF0F0, 16'h0FF0);  // R3, R8 carry held
        step(1, 8'h25, 16'h0001, 16'h0000);  // R6 carry, zero
        step(1, 8'h1D, 16'h0000, 16'hABCD);  // R4
        step(1, 8'h1D, 16'h0000, 16'h1111);  // R4 b ignored
        step(1, 8'h15, 16'h0000, 16'h0000);  // R3 zero
        step(1, 8'h19, 16'hFFFF, 16'h00FF);  // R3
        step(1, 8'h33, 16'h0000, 16'h0000);  // R9 unknown opcode
        step(0, 8'h01, 16'hFFFF, 16'h0001);  // R9 valid low
        step(1, 8'h25, 16'hFFFF, 16'h0000);  // R6 bit15 cleared
        step(1, 8'h21, 16'h4000, 16'h0000);  // R5 negative
        for (int i = 0; i < 2000; i++) begin
            ra = $urandom; rb = $urandom;
            if ($urandom_range(0, 7) == 0) rop = $urandom;
            else rop = ops[$urandom_range(0, 7)];
            step($urandom_range(0, 3) != 0, rop, ra, rb);
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule